// File: doc/BRIEF.md
# UART Modem Control and Loopback Unit

This block sits between a UART's serial and modem pins and the transmitter, receiver and modem status logic inside the UART. It holds the modem control register: two modem output bits (DTR and RTS), two spare output bits, a loopback select bit and the enable bits for automatic RTS and CTS flow control. The flow-control state machines themselves live elsewhere and only read the two enable outputs.

In normal mode the serial data and modem lines pass straight through. The four modem inputs are brought through a two-stage synchronizer into a level register that forms the upper half of the modem status value. In loopback mode the transmitter output feeds the receiver input. The external transmit pin idles high and the external RTS and DTR pins go inactive (low). The status levels are taken from the control register's low nibble instead of from the pins. This lets software test the modem status interrupt path by writing the control register alone.

The lower half of the status value holds four sticky change flags. A status read clears them. Their OR is the modem status interrupt request.

Top module: `uart_modem_loop`

## Requirements
- R1: After reset, the control readback, the status value, the interrupt request and the RTS and DTR pins are all 0.
- R2: A write stores control bits 0 to 4, 6 and 7. Bit 5 always reads 0. Bit 6 drives auto_rts_en and bit 7 drives auto_cts_en. Bit 4 selects loopback when it is 1.
- R3: In normal mode, rx_serial_out equals pin_rxd and pin_txd equals tx_serial_in.
- R4: In loopback mode, rx_serial_out equals tx_serial_in, pin_rxd has no effect, and pin_txd is 1.
- R5: In normal mode, pin_dtr equals control bit 0 and pin_rts equals control bit 1. In loopback mode both pins are 0.
- R6: In normal mode, status bits 4, 5, 6 and 7 show pin_cts, pin_dsr, pin_ri and pin_dcd. A pin change shows at the third rising edge after it and not before.
- R7: In loopback mode, status bit 4 follows control bit 1 and bit 5 follows control bit 0. Bit 6 follows control bit 2 and bit 7 follows control bit 3. The modem input pins are ignored. A write shows at the second rising edge after the write strobe is sampled.
- R8: Status bits 0, 1 and 3 set when status bit 4, 5 or 7 changes in either direction. Bit 2 sets only when status bit 6 goes from 1 to 0. Each flag sets at the same edge where the level bit updates.
- R9: A read strobe clears the change flags at the next edge. A change detected at that same edge still sets its flag.
- R10: msi_req is 1 exactly when any of status bits 0 to 3 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_q | output | 8 | Control register readback |
| auto_rts_en | output | 1 | Automatic RTS flow control enable |
| auto_cts_en | output | 1 | Automatic CTS flow control enable |
| sts_rd | input | 1 | Status read strobe; clears change flags |
| sts_q | output | 8 | Modem status value (levels 7:4, change flags 3:0) |
| msi_req | output | 1 | Modem status interrupt request |
| tx_serial_in | input | 1 | Serial data from the transmitter |
| rx_serial_out | output | 1 | Serial data to the receiver |
| pin_rxd | input | 1 | External receive pin |
| pin_txd | output | 1 | External transmit pin |
| pin_cts | input | 1 | External CTS input, 1 = asserted |
| pin_dsr | input | 1 | External DSR input, 1 = asserted |
| pin_ri | input | 1 | External RI input, 1 = asserted |
| pin_dcd | input | 1 | External DCD input, 1 = asserted |
| pin_rts | output | 1 | External RTS output, 1 = asserted |
| pin_dtr | output | 1 | External DTR output, 1 = asserted |

## Verification
A wrong level register shows up on sts_q within two edges of a loopback control write, or within three edges of a pin change. The bench samples at exactly that edge, so a lost or extra register stage is caught. A wrong change flag moves msi_req at the same edge, so a missed trailing-edge rule for RI or a bad read-clear priority is visible at once. Errors in the loopback wiring show up combinationally on pin_txd, pin_rts, pin_dtr and rx_serial_out as soon as the mode bit is stored.

// File: rtl/uml_pkg.sv
package uml_pkg;
  localparam int CTL_W   = 8;
  localparam int LINES   = 4;
  // control bit positions
  localparam int B_DTR   = 0;
  localparam int B_RTS   = 1;
  localparam int B_OUT2  = 2;
  localparam int B_OUT3  = 3;
  localparam int B_LOOP  = 4;
  localparam int B_RSV   = 5;
  localparam int B_ARTS  = 6;
  localparam int B_ACTS  = 7;
  // status nibble order: [0]=CTS [1]=DSR [2]=RI [3]=DCD
  localparam int L_CTS   = 0;
  localparam int L_DSR   = 1;
  localparam int L_RI    = 2;
  localparam int L_DCD   = 3;

  typedef logic [LINES-1:0] lines_t;

  // loopback routing of control outputs onto status lines
  function automatic lines_t loop_map(input logic [LINES-1:0] lo);
    lines_t m;
    m[L_CTS] = lo[B_RTS];
    m[L_DSR] = lo[B_DTR];
    m[L_RI]  = lo[B_OUT2];
    m[L_DCD] = lo[B_OUT3];
    return m;
  endfunction

  // change detection: any edge except RI which reports its trailing edge
  function automatic lines_t delta_of(input lines_t old_l, input lines_t new_l);
    lines_t d;
    d = old_l ^ new_l;
    d[L_RI] = old_l[L_RI] & ~new_l[L_RI];
    return d;
  endfunction
endpackage

// File: rtl/uml_ctl_reg.sv
module uml_ctl_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RSV_MASK = 8'h20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] r;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  r <= '0;
    else if (we) r <= wdata & ~RSV_MASK;
  end
  assign q = r;
endmodule

// File: rtl/uml_sync.sv
module uml_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end
  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end
  assign q = stg[STAGES-1];
endmodule

// File: rtl/uml_pin_mux.sv
module uml_pin_mux (
  input  logic loop_en,
  input  logic dtr_bit,
  input  logic rts_bit,
  input  logic tx_serial_in,
  input  logic pin_rxd,
  output logic rx_serial_out,
  output logic pin_txd,
  output logic pin_rts,
  output logic pin_dtr
);
  always_comb begin
    if (loop_en) begin
      rx_serial_out = tx_serial_in;
      pin_txd       = 1'b1;
      pin_rts       = 1'b0;
      pin_dtr       = 1'b0;
    end else begin
      rx_serial_out = pin_rxd;
      pin_txd       = tx_serial_in;
      pin_rts       = rts_bit;
      pin_dtr       = dtr_bit;
    end
  end
endmodule

// File: rtl/uml_status.sv
module uml_status
  import uml_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       loop_en,
  input  lines_t     ctl_lo,
  input  lines_t     pin_lvl,
  input  logic       sts_rd,
  output logic [7:0] sts,
  output lines_t     delta_set,
  output logic       msi
);
  lines_t src, lvl, dlt;

  assign src       = loop_en ? loop_map(ctl_lo) : pin_lvl;
  assign delta_set = delta_of(lvl, src);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= '0;
      dlt <= '0;
    end else begin
      lvl <= src;
      dlt <= (sts_rd ? '0 : dlt) | delta_set;
    end
  end

  assign sts = {lvl, dlt};
  assign msi = |dlt;
endmodule

// File: rtl/uart_modem_loop.sv
module uart_modem_loop
  import uml_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic             auto_rts_en,
  output logic             auto_cts_en,
  input  logic             sts_rd,
  output logic [7:0]       sts_q,
  output logic             msi_req,
  input  logic             tx_serial_in,
  output logic             rx_serial_out,
  input  logic             pin_rxd,
  output logic             pin_txd,
  input  logic             pin_cts,
  input  logic             pin_dsr,
  input  logic             pin_ri,
  input  logic             pin_dcd,
  output logic             pin_rts,
  output logic             pin_dtr
);
  logic [CTL_W-1:0] ctl;
  logic             loop_en;
  lines_t           pins_raw, pins_sync, delta_set;

  uml_ctl_reg #(.W(CTL_W), .RSV_MASK(8'(1 << B_RSV))) u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata), .q(ctl)
  );

  assign loop_en     = ctl[B_LOOP];
  assign ctl_q       = ctl;
  assign auto_rts_en = ctl[B_ARTS];
  assign auto_cts_en = ctl[B_ACTS];

  uml_pin_mux u_mux (
    .loop_en(loop_en), .dtr_bit(ctl[B_DTR]), .rts_bit(ctl[B_RTS]),
    .tx_serial_in(tx_serial_in), .pin_rxd(pin_rxd),
    .rx_serial_out(rx_serial_out), .pin_txd(pin_txd),
    .pin_rts(pin_rts), .pin_dtr(pin_dtr)
  );

  always_comb begin
    pins_raw        = '0;
    pins_raw[L_CTS] = pin_cts;
    pins_raw[L_DSR] = pin_dsr;
    pins_raw[L_RI]  = pin_ri;
    pins_raw[L_DCD] = pin_dcd;
  end

  uml_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_sync)
  );

  uml_status u_sts (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .ctl_lo(ctl[LINES-1:0]),
    .pin_lvl(pins_sync), .sts_rd(sts_rd), .sts(sts_q),
    .delta_set(delta_set), .msi(msi_req)
  );
endmodule

// File: rtl/uml_checker.sv
module uml_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctl_q,
  input logic [7:0] sts_q,
  input logic       sts_rd,
  input logic       pin_txd,
  input logic       pin_rts,
  input logic       pin_dtr,
  input logic [3:0] delta_set
);
  p_loop_txd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[4] |-> pin_txd);

  p_loop_modem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[4] |-> (!pin_rts && !pin_dtr));

  p_loop_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[4] && $past(ctl_q[4])) |-> (sts_q[4] == $past(ctl_q[1]) && sts_q[5] == $past(ctl_q[0])));

  p_cts_delta_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[4] != $past(sts_q[4])) |-> sts_q[0]);

  p_ri_trail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sts_q[6]) && !sts_q[6]) |-> sts_q[2]);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_rd && sts_q[1]) |=> sts_q[1]);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && delta_set == 4'b0) |=> (sts_q[3:0] == 4'b0));
endmodule

bind uart_modem_loop uml_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .sts_q(sts_q), .sts_rd(sts_rd),
  .pin_txd(pin_txd), .pin_rts(pin_rts), .pin_dtr(pin_dtr), .delta_set(delta_set)
);

// File: tb/uart_modem_loop_test.sv
module uart_modem_loop_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_q, sts_q;
  logic auto_rts_en, auto_cts_en, msi_req;
  logic sts_rd = 1'b0;
  logic tx_serial_in = 1'b0, pin_rxd = 1'b0;
  logic rx_serial_out, pin_txd, pin_rts, pin_dtr;
  logic pin_cts = 0, pin_dsr = 0, pin_ri = 0, pin_dcd = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_modem_loop uut (.*);

  // {ctl write value, expected status upper nibble} in loopback
  localparam logic [11:0] VEC [8] = '{
    {8'h10, 4'h0}, {8'h11, 4'h2}, {8'h12, 4'h1}, {8'h14, 4'h4},
    {8'h18, 4'h8}, {8'h13, 4'h3}, {8'h1F, 4'hF}, {8'h15, 4'h6}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic rd_clear();
    @(negedge clk); sts_rd = 1'b1;
    @(negedge clk); sts_rd = 1'b0;
  endtask

  task automatic set_pins(input logic [3:0] v); // {dcd,ri,dsr,cts}
    @(negedge clk);
    {pin_dcd, pin_ri, pin_dsr, pin_cts} = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 ctl", ctl_q, 8'h00);
    chk("R1 sts", sts_q, 8'h00);
    chk("R1 irq/rts/dtr", {5'b0, msi_req, pin_rts, pin_dtr}, 8'h00);

    // R2 control storage, R5 normal modem outputs
    wr(8'hEF); #1;
    chk("R2 ctl bit5 zero", ctl_q, 8'hCF);
    chk("R2 auto enables", {6'b0, auto_cts_en, auto_rts_en}, 8'h03);
    chk("R5 normal rts/dtr", {6'b0, pin_rts, pin_dtr}, 8'h03);
    wr(8'h00); #1;
    chk("R5 normal rts/dtr off", {6'b0, pin_rts, pin_dtr}, 8'h00);

    // R3 normal serial passthrough
    tx_serial_in = 1'b1; pin_rxd = 1'b0; #1;
    chk("R3 pass", {6'b0, pin_txd, rx_serial_out}, 8'h02);
    tx_serial_in = 1'b0; pin_rxd = 1'b1; #1;
    chk("R3 pass b", {6'b0, pin_txd, rx_serial_out}, 8'h01);

    // R6 pin latency, R8 deltas, R10 irq
    set_pins(4'b1001);
    @(negedge clk); @(negedge clk);
    chk("R6 not yet at 2nd edge", sts_q, 8'h00);
    @(negedge clk);
    chk("R6 R8 cts+dcd", sts_q, 8'h99);
    chk("R10 irq set", {7'b0, msi_req}, 8'h01);
    rd_clear();
    chk("R9 cleared", sts_q, 8'h90);
    chk("R10 irq clear", {7'b0, msi_req}, 8'h00);

    // R8 RI: rising edge gives no flag, falling edge does
    set_pins(4'b1101);
    repeat (3) @(negedge clk);
    chk("R8 ri rise no flag", sts_q, 8'hD0);
    set_pins(4'b1001);
    repeat (3) @(negedge clk);
    chk("R8 ri fall flag", sts_q, 8'h94);
    set_pins(4'b0000);
    repeat (3) @(negedge clk);
    rd_clear();
    chk("R6 idle", sts_q, 8'h00);

    // loopback: pins all active must be ignored
    set_pins(4'b1111);
    wr(8'h10);
    @(negedge clk);
    tx_serial_in = 1'b0; pin_rxd = 1'b1; #1;
    chk("R4 txd mark", {7'b0, pin_txd}, 8'h01);
    chk("R4 rx from tx", {7'b0, rx_serial_out}, 8'h00);
    tx_serial_in = 1'b1; pin_rxd = 1'b0; #1;
    chk("R4 rx from tx b", {7'b0, rx_serial_out}, 8'h01);
    chk("R7 pins ignored", sts_q, 8'h00);

    // R7 table walk
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][11:4]);
      @(negedge clk);
      chk("R7 loop map", {4'h0, sts_q[7:4]}, {4'h0, VEC[i][3:0]});
      chk("R5 loop pins inactive", {6'b0, pin_rts, pin_dtr}, 8'h00);
    end

    // R9 read/change collision in loopback
    wr(8'h10); @(negedge clk);
    rd_clear();
    chk("R9 clean", sts_q, 8'h00);
    wr(8'h12); @(negedge clk);
    chk("R8 loop cts flag", sts_q, 8'h11);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 8'h13;
    @(negedge clk); ctl_we = 1'b0; sts_rd = 1'b1;
    @(negedge clk); sts_rd = 1'b0;
    chk("R9 set wins over clear", sts_q, 8'h32);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule